// File: doc/BRIEF.md
# Preemptive Priority Interrupt Arbiter

This block merges a bank of interrupt request lines into one request to the processor. Each line has its own programmable priority. The lowest eight lines belong to a software-driven flag bank. The lines above them belong to peripheral flags. Every line has a fixed vector equal to its line number, carried on nine bits.

Each clock, the asserted lines are ranked by priority. The winning priority is then compared against a current-priority register that software loads. The processor request rises only when the winner is strictly more urgent than the work already running. A request travels from a source line to the processor output in a fixed three-stage pipeline:

- the input register,
- the arbitration register,
- the preemption/output register.

While the request is raised, the presented vector stays fixed for as long as its source is still pending and still preempts. When that stops being true, the next winner is loaded. If there is no winner, the output drops.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset the processor request is 0, the vector is 0, every source priority is 0 and the current priority is 0, so asserting all request lines raises nothing.
- R2: The vector presented for source line n is n, zero-extended to 9 bits. Lines 0–7 are the software sources and yield vectors 0–7. Peripheral lines yield 8 and upward.
- R3: Among asserted sources, the one with the numerically largest 4-bit priority wins.
- R4: When asserted sources share the highest priority, the one with the lowest line number wins.
- R5: A source whose priority is 0 never wins and never raises the request.
- R6: The request is raised only when the winning priority is strictly greater than the current priority. Equal does not preempt.
- R7: A line asserted before clock edge k raises the processor request right after edge k+2 (three clocks), and not earlier.
- R8: Whenever the processor request is 0, the vector output is 0.
- R9: While raised, request and vector stay unchanged as long as the presented source is still pending at the arbitration stage and its priority still exceeds the current priority. This holds even if a more urgent source arrives. After the presented source deasserts, the next winner appears three clocks later.
- R10: A current-priority load written at edge k is used by the comparison at edge k+1, not at edge k. If the presented source no longer preempts after the load, the request drops at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Request lines, bit n is source n |
| pri_we | input | 1 | Write strobe for one source priority |
| pri_wsel | input | SEL_W | Source index for the priority write |
| pri_wdata | input | PRI_W | Priority value to write |
| cur_pri_we | input | 1 | Load strobe for the current priority |
| cur_pri_wdata | input | PRI_W | New current priority |
| cpu_irq | output | 1 | Request to the processor |
| cpu_vec | output | VEC_W | Vector of the presented source, 0 when idle |

## Verification
The interesting collision is a current-priority load landing on the same edge as the output stage's compare of a freshly arbitrated winner. The bench provokes it by timing the load strobe so that it sits on the third edge after a line is raised. It expects the request to rise on that edge, using the old current priority. It then expects the request to drop on the next edge, because the newly loaded value blocks it. A second collision is a more urgent line arriving while a vector is held. The bench checks that the held vector survives until its own source leaves, and that the newcomer takes over exactly three clocks later.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int unsigned DEF_NUM_SRC = 32;
   localparam int unsigned DEF_PRI_W   = 4;
   localparam int unsigned DEF_VEC_W   = 9;
   localparam int unsigned DEF_NUM_SW  = 8;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/prio_irq_pri_file.sv
module prio_irq_pri_file #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned PRI_W   = 4,
   parameter int unsigned SEL_W   = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            pri_we,
   input  logic [SEL_W-1:0]                pri_wsel,
   input  logic [PRI_W-1:0]                pri_wdata,
   input  logic                            cur_pri_we,
   input  logic [PRI_W-1:0]                cur_pri_wdata,
   output logic [NUM_SRC-1:0][PRI_W-1:0]   pri_tbl,
   output logic [PRI_W-1:0]                cur_pri
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_pri
      always_ff @(posedge clk) begin
         if (!rst_n)
            pri_tbl[g] <= '0;
         else if (pri_we && (pri_wsel == SEL_W'(g)))
            pri_tbl[g] <= pri_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cur_pri <= '0;
      else if (cur_pri_we)
         cur_pri <= cur_pri_wdata;
   end

   // R1: after reset the current priority is zero until written
   assert_cur_reset_R1: assert property (@(posedge clk)
      $past(!rst_n) |-> (cur_pri == '0));
endmodule

// File: rtl/prio_irq_arb_stage.sv
module prio_irq_arb_stage #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned PRI_W   = 4,
   parameter int unsigned SEL_W   = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SRC-1:0]              req,
   input  logic [NUM_SRC-1:0][PRI_W-1:0]   pri_tbl,
   output logic                            win_valid,
   output logic [SEL_W-1:0]                win_idx,
   output logic [PRI_W-1:0]                win_pri,
   output logic [NUM_SRC-1:0]              pend
);
   logic [PRI_W-1:0] best_pri;
   logic [SEL_W-1:0] best_idx;

   // ascending scan with strict compare keeps the lowest index on ties
   always_comb begin
      best_pri = '0;
      best_idx = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req[i] && (pri_tbl[i] > best_pri)) begin
            best_pri = pri_tbl[i];
            best_idx = SEL_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_valid <= 1'b0;
         win_idx   <= '0;
         win_pri   <= '0;
         pend      <= '0;
      end else begin
         win_valid <= (best_pri != '0);
         win_idx   <= best_idx;
         win_pri   <= best_pri;
         pend      <= req;
      end
   end

   // R5: a registered winner never carries the masking priority
   assert_no_masked_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_pri != '0));
   // R3: the registered winner was a pending request
   assert_win_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> pend[win_idx]);
endmodule

// File: rtl/prio_irq_out_stage.sv
module prio_irq_out_stage #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned PRI_W   = 4,
   parameter int unsigned SEL_W   = 5,
   parameter int unsigned VEC_W   = 9
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            win_valid,
   input  logic [SEL_W-1:0]                win_idx,
   input  logic [PRI_W-1:0]                win_pri,
   input  logic [NUM_SRC-1:0]              pend,
   input  logic [NUM_SRC-1:0][PRI_W-1:0]   pri_tbl,
   input  logic [PRI_W-1:0]                cur_pri,
   output logic                            cpu_irq,
   output logic [VEC_W-1:0]                cpu_vec
);
   logic [SEL_W-1:0] held_idx;
   logic             keep;
   logic             raise;

   assign keep  = cpu_irq && pend[held_idx] && (pri_tbl[held_idx] > cur_pri);
   assign raise = win_valid && (win_pri > cur_pri);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_irq  <= 1'b0;
         cpu_vec  <= '0;
         held_idx <= '0;
      end else if (!keep) begin
         cpu_irq  <= raise;
         cpu_vec  <= raise ? VEC_W'(win_idx) : '0;
         held_idx <= raise ? win_idx : '0;
      end
   end

   // R8: idle output carries vector zero
   assert_idle_vec_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq |-> (cpu_vec == '0));
   // R9: a held, still-preempting source keeps request and vector
   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && pend[held_idx] && (pri_tbl[held_idx] > cur_pri))
         |=> (cpu_irq && $stable(cpu_vec)));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = DEF_NUM_SRC,
   parameter int unsigned PRI_W   = DEF_PRI_W,
   parameter int unsigned VEC_W   = DEF_VEC_W,
   parameter int unsigned NUM_SW  = DEF_NUM_SW,
   localparam int unsigned SEL_W  = idx_bits(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               pri_we,
   input  logic [SEL_W-1:0]   pri_wsel,
   input  logic [PRI_W-1:0]   pri_wdata,
   input  logic               cur_pri_we,
   input  logic [PRI_W-1:0]   cur_pri_wdata,
   output logic               cpu_irq,
   output logic [VEC_W-1:0]   cpu_vec
);
   if (NUM_SRC > (1 << VEC_W)) begin : g_chk_vec
      $error("NUM_SRC does not fit in the vector width");
   end
   if (NUM_SRC <= NUM_SW) begin : g_chk_sw
      $error("NUM_SRC must exceed the software source count");
   end
   if (SEL_W > VEC_W) begin : g_chk_sel
      $error("index width exceeds vector width");
   end

   logic [NUM_SRC-1:0]              req_q;
   logic [NUM_SRC-1:0][PRI_W-1:0]   pri_tbl;
   logic [PRI_W-1:0]                cur_pri;
   logic                            win_valid;
   logic [SEL_W-1:0]                win_idx;
   logic [PRI_W-1:0]                win_pri;
   logic [NUM_SRC-1:0]              pend;

   // stage 1: capture request lines
   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= irq_in;
   end

   prio_irq_pri_file #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .SEL_W(SEL_W)) u_pri (
      .clk(clk), .rst_n(rst_n),
      .pri_we(pri_we), .pri_wsel(pri_wsel), .pri_wdata(pri_wdata),
      .cur_pri_we(cur_pri_we), .cur_pri_wdata(cur_pri_wdata),
      .pri_tbl(pri_tbl), .cur_pri(cur_pri));

   // stage 2: arbitration
   prio_irq_arb_stage #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .SEL_W(SEL_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_q), .pri_tbl(pri_tbl),
      .win_valid(win_valid), .win_idx(win_idx), .win_pri(win_pri), .pend(pend));

   // stage 3: preemption compare and output
   prio_irq_out_stage #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .SEL_W(SEL_W), .VEC_W(VEC_W)) u_out (
      .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
      .win_pri(win_pri), .pend(pend), .pri_tbl(pri_tbl), .cur_pri(cur_pri),
      .cpu_irq(cpu_irq), .cpu_vec(cpu_vec));

   // R7: a rising request traces back to a line asserted three clocks earlier
   assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_irq) |-> $past(|irq_in, 3));
   // R2: presented vector always names an existing source
   assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (cpu_vec < VEC_W'(NUM_SRC)));
endmodule

// File: tb/sim_prio_irq_arbiter.sv
module sim_prio_irq_arbiter;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic        pri_we = 1'b0;
   logic [4:0]  pri_wsel = '0;
   logic [3:0]  pri_wdata = '0;
   logic        cur_pri_we = 1'b0;
   logic [3:0]  cur_pri_wdata = '0;
   logic        cpu_irq;
   logic [8:0]  cpu_vec;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   prio_irq_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .pri_we(pri_we), .pri_wsel(pri_wsel), .pri_wdata(pri_wdata),
      .cur_pri_we(cur_pri_we), .cur_pri_wdata(cur_pri_wdata),
      .cpu_irq(cpu_irq), .cpu_vec(cpu_vec));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_pri(input int idx, input int val);
      pri_we = 1'b1; pri_wsel = 5'(idx); pri_wdata = 4'(val);
      tick(1);
      pri_we = 1'b0;
   endtask

   task automatic set_cur(input int val);
      cur_pri_we = 1'b1; cur_pri_wdata = 4'(val);
      tick(1);
      cur_pri_we = 1'b0;
   endtask

   task automatic idle();
      irq_in = '0;
      tick(4);
   endtask

   function automatic int pat_pri(input int k);
      return (k * 7 + 3) % 16;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk(cpu_irq == 1'b0, "R1 irq", int'(cpu_irq), 0);
      chk(cpu_vec == 9'd0, "R1 vec", int'(cpu_vec), 0);
      irq_in = '1;
      tick(5);
      chk(cpu_irq == 1'b0, "R1 all masked", int'(cpu_irq), 0);
      idle();

      // R2: each source alone with top priority presents its own number
      for (int k = 0; k < N; k++) set_pri(k, 15);
      for (int k = 0; k < N; k++) begin
         irq_in = '0; irq_in[k] = 1'b1;
         tick(3);
         chk(cpu_irq && cpu_vec == 9'(k), "R2 vector", int'(cpu_vec), k);
         idle();
      end

      // R7 latency: low after two edges, high after the third
      irq_in = '0; irq_in[9] = 1'b1;
      tick(2);
      chk(cpu_irq == 1'b0, "R7 early", int'(cpu_irq), 0);
      tick(1);
      chk(cpu_irq == 1'b1, "R7 on time", int'(cpu_irq), 1);
      idle();

      // R3 R4 R5 R6 R8 pair sweep with arithmetic priorities
      for (int k = 0; k < N; k++) set_pri(k, pat_pri(k));
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            int bp, bi, cur;
            bit exp_irq;
            bp = 0; bi = 0;
            if (pat_pri(i) > bp) begin bp = pat_pri(i); bi = i; end
            if (pat_pri(j) > bp || (pat_pri(j) == bp && bp != 0 && j < bi)) begin
               bp = pat_pri(j); bi = j;
            end
            cur = (i + j) % 16;
            exp_irq = (bp > cur);
            set_cur(cur);
            irq_in = '0; irq_in[i] = 1'b1; irq_in[j] = 1'b1;
            tick(3);
            chk(cpu_irq == exp_irq, "R3 R5 R6 request", int'(cpu_irq), int'(exp_irq));
            chk(cpu_vec == (exp_irq ? 9'(bi) : 9'd0), "R4 R8 vector",
                int'(cpu_vec), exp_irq ? bi : 0);
            idle();
         end
      end

      // R6 explicit equality boundary
      for (int k = 0; k < N; k++) set_pri(k, 0);
      set_pri(5, 5);
      set_cur(5);
      irq_in = '0; irq_in[5] = 1'b1;
      tick(4);
      chk(cpu_irq == 1'b0, "R6 equal no preempt", int'(cpu_irq), 0);
      idle();
      set_cur(4);
      irq_in[5] = 1'b1;
      tick(3);
      chk(cpu_irq && cpu_vec == 9'd5, "R6 greater preempts", int'(cpu_vec), 5);
      idle();

      // R9 hold while a more urgent source arrives
      set_cur(0);
      set_pri(3, 4);
      set_pri(20, 9);
      irq_in = '0; irq_in[3] = 1'b1;
      tick(3);
      chk(cpu_vec == 9'd3, "R9 first", int'(cpu_vec), 3);
      irq_in[20] = 1'b1;
      tick(5);
      chk(cpu_irq && cpu_vec == 9'd3, "R9 held", int'(cpu_vec), 3);
      irq_in[3] = 1'b0;
      tick(2);
      chk(cpu_irq && cpu_vec == 9'd3, "R9 still held", int'(cpu_vec), 3);
      tick(1);
      chk(cpu_irq && cpu_vec == 9'd20, "R9 handover", int'(cpu_vec), 20);
      idle();

      // R10 current-priority load on the compare edge
      set_cur(2);
      irq_in = '0; irq_in[5] = 1'b1;
      tick(2);
      cur_pri_we = 1'b1; cur_pri_wdata = 4'd9;
      tick(1);
      cur_pri_we = 1'b0;
      chk(cpu_irq && cpu_vec == 9'd5, "R10 old value used", int'(cpu_irq), 1);
      tick(1);
      chk(cpu_irq == 1'b0, "R10 drop", int'(cpu_irq), 0);
      chk(cpu_vec == 9'd0, "R10 R8 vec zero", int'(cpu_vec), 0);
      idle();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule